// File: doc/BRIEF.md
# VLAN Violation Capture Unit

This block sits next to the VLAN table lookup of a switch. Each lookup result arrives as an event carrying a 13-bit VLAN ID, the source port and two flags. The miss flag means the VID has no table entry. The member flag means the source port is not a member of that VLAN. An event with either flag set is a violation. The block keeps the first violation it sees in a single slot and raises an interrupt to the host.

The host services the interrupt through the shared operation register. It writes a get-and-clear command with the busy bit set and polls until busy drops. The operation register then holds the source port and the two violation flags, and the VID register holds the offending VID. The same step empties the slot. Violations that arrive while the slot is full are dropped and recorded in a sticky overflow bit. The next get-and-clear reports that bit and clears it.

Top module: `vviol_unit`

## Requirements
- R1: An event is a violation when `evt_valid_i` is high and `evt_miss_i` or `evt_member_i` is high. When the slot is empty, a violation is captured at that clock edge. A valid event with both flags low is ignored.
- R2: `irq_o` rises on the clock after a violation is captured. It stays high until get-and-clear completes. It is still high in the cycle in which busy reads 0, and it is low one clock later.
- R3: A write to the operation register starts get-and-clear only when all three hold: bit 15 (busy) is 1, bits 14:12 are 3'b111, and no command is running. Busy then reads 1 for exactly OP_LAT cycles and then 0. Any other write leaves the operation register and `irq_o` unchanged.
- R4: After get-and-clear, operation register bits 3:0 give the source port, bit 5 the miss violation and bit 6 the member violation. Both flags can be 1 at once. Bits 14:12 read back 3'b111.
- R5: After get-and-clear, VID register bits 11:0 hold VID bits 11:0, and bit 13 (the page bit) holds VID bit 12. All other bits of the VID register read 0.
- R6: A violation that arrives while one is pending is dropped and sets a sticky overflow flag. The next get-and-clear returns that flag in operation register bit 8 and clears it.
- R7: Get-and-clear with nothing pending returns the port, both violation flags, the overflow bit and the VID as 0.
- R8: A violation that arrives in the completion cycle of a get-and-clear, while a violation is pending, counts as arriving while pending. The command returns the old record with overflow 0, and the next command reports overflow 1.
- R9: After reset, `irq_o`, the operation register and the VID register all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Lookup event strobe |
| evt_vid_i | input | 13 | VID of the looked-up frame |
| evt_port_i | input | 4 | Source port of the frame |
| evt_miss_i | input | 1 | VID not found in the table |
| evt_member_i | input | 1 | Source port is not a member of the VLAN |
| op_wr_i | input | 1 | Write strobe for the operation register |
| op_wdata_i | input | 16 | Operation register write data |
| op_rdata_o | output | 16 | Operation register read value |
| vid_rdata_o | output | 16 | VID register read value |
| irq_o | output | 1 | Violation interrupt |

## Verification
A violation is captured at the edge where it is presented, and `irq_o` follows one edge later. The bench therefore drives events on a falling edge and checks the interrupt two falling edges after that. For get-and-clear, the bench counts the falling edges on which busy reads 1 and expects OP_LAT of them. The result registers and the still-high interrupt are sampled on the first falling edge with busy at 0, and the low interrupt is checked one falling edge later. For the completion-cycle case, the bench presents the event on the last busy falling edge, so that the event and completion meet at the same clock edge.

// File: rtl/vviol_pkg.sv
package vviol_pkg;
  localparam int unsigned VID_W    = 13;
  localparam int unsigned PORT_W   = 4;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned VID_LO_W = 12;
  // operation register fields
  localparam int unsigned BUSY_B   = 15;
  localparam int unsigned OPC_LSB  = 12;
  localparam int unsigned OPC_W    = 3;
  localparam int unsigned OVF_B    = 8;
  localparam int unsigned MEM_B    = 6;
  localparam int unsigned MISS_B   = 5;
  // VID register page bit
  localparam int unsigned PAGE_B   = 13;
  localparam logic [OPC_W-1:0] OPC_GETCLR = 3'b111;

  typedef struct packed {
    logic [VID_W-1:0]  vid;
    logic [PORT_W-1:0] port;
    logic              miss;
    logic              member;
  } viol_t;
endpackage

// File: rtl/vviol_cmd.sv
module vviol_cmd
  import vviol_pkg::*;
#(
  parameter int unsigned OP_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_wr_i,
  input  logic [REG_W-1:0] op_wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [OPC_W-1:0] opc_o
);
  localparam int unsigned CNT_W = (OP_LAT > 1) ? $clog2(OP_LAT) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OPC_W-1:0] opc_q;
  logic             start;
  logic             unused_wdata;

  assign unused_wdata = ^op_wdata_i[OPC_LSB-1:0];
  assign start = op_wr_i && op_wdata_i[BUSY_B] && !busy_q &&
                 (op_wdata_i[OPC_LSB +: OPC_W] == OPC_GETCLR);
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      opc_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(OP_LAT - 1);
      opc_q  <= op_wdata_i[OPC_LSB +: OPC_W];
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign opc_o  = opc_q;
endmodule

// File: rtl/vviol_capture.sv
module vviol_capture
  import vviol_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [VID_W-1:0]  evt_vid_i,
  input  logic [PORT_W-1:0] evt_port_i,
  input  logic              evt_miss_i,
  input  logic              evt_member_i,
  input  logic              done_i,
  output logic              pend_o,
  output viol_t             rec_o,
  output logic              ovf_o
);
  logic  pend_q, ovf_q, viol;
  viol_t rec_q;

  assign viol = evt_valid_i && (evt_miss_i || evt_member_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rec_q  <= '0;
    end else if (viol && !pend_q) begin
      pend_q <= 1'b1;
      rec_q  <= '{vid: evt_vid_i, port: evt_port_i,
                  miss: evt_miss_i, member: evt_member_i};
    end else if (done_i) begin
      pend_q <= 1'b0;
    end
  end

  // drop while pending; a drop in the completion cycle survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovf_q <= 1'b0;
    else if (done_i)            ovf_q <= viol && pend_q;
    else if (viol && pend_q)    ovf_q <= 1'b1;
  end

  assign pend_o = pend_q;
  assign rec_o  = rec_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/vviol_regs.sv
module vviol_regs
  import vviol_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             busy_i,
  input  logic [OPC_W-1:0] opc_i,
  input  logic             pend_i,
  input  viol_t            rec_i,
  input  logic             ovf_i,
  output logic [REG_W-1:0] op_rdata_o,
  output logic [REG_W-1:0] vid_rdata_o
);
  viol_t res_q;
  logic  ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (done_i) begin
      res_q <= pend_i ? rec_i : '0;
      ovf_q <= ovf_i;
    end
  end

  always_comb begin
    op_rdata_o                       = '0;
    op_rdata_o[BUSY_B]               = busy_i;
    op_rdata_o[OPC_LSB +: OPC_W]     = opc_i;
    op_rdata_o[OVF_B]                = ovf_q;
    op_rdata_o[MEM_B]                = res_q.member;
    op_rdata_o[MISS_B]               = res_q.miss;
    op_rdata_o[PORT_W-1:0]           = res_q.port;
    vid_rdata_o                      = '0;
    vid_rdata_o[VID_LO_W-1:0]        = res_q.vid[VID_LO_W-1:0];
    vid_rdata_o[PAGE_B]              = res_q.vid[VID_W-1];
  end
endmodule

// File: rtl/vviol_unit.sv
module vviol_unit
  import vviol_pkg::*;
#(
  parameter int unsigned OP_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [VID_W-1:0]  evt_vid_i,
  input  logic [PORT_W-1:0] evt_port_i,
  input  logic              evt_miss_i,
  input  logic              evt_member_i,
  input  logic              op_wr_i,
  input  logic [REG_W-1:0]  op_wdata_i,
  output logic [REG_W-1:0]  op_rdata_o,
  output logic [REG_W-1:0]  vid_rdata_o,
  output logic              irq_o
);
  logic             busy, done, pend, ovf, irq_q;
  logic [OPC_W-1:0] opc;
  viol_t            rec;

  vviol_cmd #(.OP_LAT(OP_LAT)) u_cmd (
    .clk_i, .rst_ni, .op_wr_i, .op_wdata_i,
    .busy_o(busy), .done_o(done), .opc_o(opc)
  );

  vviol_capture u_cap (
    .clk_i, .rst_ni, .evt_valid_i, .evt_vid_i, .evt_port_i,
    .evt_miss_i, .evt_member_i, .done_i(done),
    .pend_o(pend), .rec_o(rec), .ovf_o(ovf)
  );

  vviol_regs u_regs (
    .clk_i, .rst_ni, .done_i(done), .busy_i(busy), .opc_i(opc),
    .pend_i(pend), .rec_i(rec), .ovf_i(ovf),
    .op_rdata_o, .vid_rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pend;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/vviol_unit_chk.sv
module vviol_unit_chk
  import vviol_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_valid_i,
  input logic             evt_miss_i,
  input logic             evt_member_i,
  input logic [REG_W-1:0] op_rdata_o,
  input logic             irq_o,
  input logic             pend,
  input logic             done,
  input logic             busy,
  input logic             ovf,
  input viol_t            rec
);
  // R2
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |=> irq_o);
  // R2
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend |=> !irq_o);
  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> op_rdata_o[BUSY_B]);
  // R3
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !op_rdata_o[BUSY_B]);
  // R6
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !done) |=> (pend && $stable(rec)));
  // R6
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && evt_valid_i && (evt_miss_i || evt_member_i)) |=> ovf);
  // R7
  empty_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !pend) |=> (op_rdata_o[PORT_W-1:0] == '0 &&
                         !op_rdata_o[MISS_B] && !op_rdata_o[MEM_B]));
endmodule

bind vviol_unit vviol_unit_chk u_chk (
  .clk_i, .rst_ni, .evt_valid_i, .evt_miss_i, .evt_member_i,
  .op_rdata_o, .irq_o, .pend(pend), .done(done), .busy(busy),
  .ovf(ovf), .rec(rec)
);

// File: tb/vviol_unit_bench.sv
module vviol_unit_bench;
  localparam int OP_LAT = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_valid_i = 1'b0;
  logic [12:0] evt_vid_i = '0;
  logic [3:0]  evt_port_i = '0;
  logic        evt_miss_i = 1'b0;
  logic        evt_member_i = 1'b0;
  logic        op_wr_i = 1'b0;
  logic [15:0] op_wdata_i = '0;
  logic [15:0] op_rdata_o, vid_rdata_o;
  logic        irq_o;

  int errs = 0;
  int checks = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  vviol_unit #(.OP_LAT(OP_LAT)) u_vviol_unit (
    .clk_i(clk), .rst_ni, .evt_valid_i, .evt_vid_i, .evt_port_i,
    .evt_miss_i, .evt_member_i, .op_wr_i, .op_wdata_i,
    .op_rdata_o, .vid_rdata_o, .irq_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] op_exp(input logic [3:0] p, input logic mi,
                                         input logic me, input logic ov);
    return 16'h7000 | (16'(ov) << 8) | (16'(me) << 6) | (16'(mi) << 5) | 16'(p);
  endfunction

  function automatic logic [15:0] vid_exp(input logic [12:0] v);
    return {2'b00, v[12], 1'b0, v[11:0]};
  endfunction

  task automatic inject(input logic [3:0] p, input logic [12:0] v,
                        input logic mi, input logic me);
    @(negedge clk);
    evt_valid_i = 1'b1; evt_port_i = p; evt_vid_i = v;
    evt_miss_i = mi; evt_member_i = me;
    @(negedge clk);
    evt_valid_i = 1'b0; evt_miss_i = 1'b0; evt_member_i = 1'b0;
  endtask

  task automatic write_op(input logic [15:0] d);
    @(negedge clk);
    op_wr_i = 1'b1; op_wdata_i = d;
    @(negedge clk);
    op_wr_i = 1'b0;
  endtask

  // runs get-and-clear and checks the result against the expected record
  task automatic getclr(input logic irq_exp, input logic [3:0] p, input logic [12:0] v,
                        input logic mi, input logic me, input logic ov);
    int n = 0;
    write_op(16'hF000);
    while (op_rdata_o[15] && n < 20) begin n++; @(negedge clk); end
    check("R3 busy cycles", n, OP_LAT);
    check("R2 irq at busy fall", irq_o, irq_exp);
    check("R4/R6/R7 op register", op_rdata_o, op_exp(p, mi, me, ov));
    check("R5/R7 vid register", vid_rdata_o, vid_exp(v));
    @(negedge clk);
    check("R2 irq after clear", irq_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 irq", irq_o, 1'b0);
    check("R9 op", op_rdata_o, 16'h0);
    check("R9 vid", vid_rdata_o, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R5 sweep over ports, flag kinds and VIDs
    for (int i = 0; i < 48; i++) begin
      logic [3:0]  p  = 4'(i % 16);
      logic [12:0] v  = 13'((i * 331 + 7) % 8192);
      logic        mi = (i % 3) != 1;
      logic        me = (i % 3) != 0;
      inject(p, v, mi, me);
      check("R2 irq not yet", irq_o, 1'b0);
      @(negedge clk);
      check("R1/R2 irq raised", irq_o, 1'b1);
      getclr(1'b1, p, v, mi, me, 1'b0);
    end

    // R1 valid event without flags is ignored
    inject(4'd9, 13'h1abc, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 no-flag event irq", irq_o, 1'b0);
    getclr(1'b0, 4'd0, 13'd0, 1'b0, 1'b0, 1'b0);

    // R7 empty get-and-clear
    getclr(1'b0, 4'd0, 13'd0, 1'b0, 1'b0, 1'b0);

    // R6 second violation dropped, overflow reported then cleared
    inject(4'd5, 13'h1234, 1'b1, 1'b0);
    inject(4'd11, 13'h0777, 1'b0, 1'b1);
    inject(4'd2, 13'h0002, 1'b1, 1'b1);
    getclr(1'b1, 4'd5, 13'h1234, 1'b1, 1'b0, 1'b1);
    getclr(1'b0, 4'd0, 13'd0, 1'b0, 1'b0, 1'b0);

    // R3 non-command writes are ignored
    inject(4'd7, 13'h0abc, 1'b1, 1'b1);
    write_op(16'hE000);
    check("R3 wrong opcode op", op_rdata_o, op_exp(4'd0, 1'b0, 1'b0, 1'b0));
    write_op(16'h7000);
    check("R3 no busy bit op", op_rdata_o, op_exp(4'd0, 1'b0, 1'b0, 1'b0));
    check("R3 irq kept", irq_o, 1'b1);
    getclr(1'b1, 4'd7, 13'h0abc, 1'b1, 1'b1, 1'b0);

    // R8 violation in the completion cycle
    inject(4'd3, 13'h1001, 1'b0, 1'b1);
    @(negedge clk);
    op_wr_i = 1'b1; op_wdata_i = 16'hF000;
    @(negedge clk);
    op_wr_i = 1'b0;
    @(negedge clk);
    evt_valid_i = 1'b1; evt_port_i = 4'd14; evt_vid_i = 13'h0042; evt_miss_i = 1'b1;
    @(negedge clk);
    evt_valid_i = 1'b0; evt_miss_i = 1'b0;
    check("R8 busy low", op_rdata_o[15], 1'b0);
    check("R8 op", op_rdata_o, op_exp(4'd3, 1'b0, 1'b1, 1'b0));
    check("R8 vid", vid_rdata_o, vid_exp(13'h1001));
    @(negedge clk);
    check("R8 irq cleared", irq_o, 1'b0);
    getclr(1'b0, 4'd0, 13'd0, 1'b0, 1'b0, 1'b1);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule